// File: doc/BRIEF.md
# Compact 16-bit Single-Cycle Processor

This block is a small load/store processor that completes one 16-bit instruction on every rising clock edge. Nothing is pipelined. Each instruction word is split into four 4-bit fields. The top field is a single opcode that selects one of sixteen operations. The three lower fields carry register numbers, a 4-bit signed immediate, a shift amount, or, when taken together, a 12-bit jump address. The core holds the program counter and next-PC selection, a sixteen-entry register file, the ALU and the two-level decoder. It also contains two internal memories: one for instructions and one for data.

Before reset is released, the surrounding environment writes a program into instruction memory through a word-wide load port. Results can be observed afterwards through a combinational read port on data memory. Addresses are in bytes, so consecutive instructions are two bytes apart and word offsets are doubled before they are added to the PC. Data memory is 256 bytes organised as aligned 16-bit words.

Top module: `cpu16_core`

## Requirements
- R1: While `rst` is high on a rising edge, the PC and every register become zero. The PC reads zero on the first edge after `rst` is high.
- R2: Any instruction that is not a taken branch, a jump or a register jump advances the PC by exactly 2. The PC is always even.
- R3: Opcodes 0 add, 1 sub, 2 and, 3 or, 4 slt (signed, result 1 or 0), 14 nor and 15 xor read source registers from bits [11:8] and [7:4]. They write the register named in bits [3:0].
- R4: Opcode 5 (shift left) and opcode 6 (logical shift right) shift the register in [11:8] by the 4-bit amount in [3:0]. The result is written to the register in [7:4].
- R5: Opcode 7 adds the register in [11:8] to the immediate in [3:0]. The immediate is sign-extended and ranges from -8 to 7. The sum is written to the register in [7:4].
- R6: Opcode 8 (load) and opcode 9 (store) use the byte address formed by adding the register in [11:8] to the sign-extended immediate. Bit 0 of that address is ignored and 128 words are addressable. A load writes the register in [7:4]; a store writes that register's value to memory. A store never writes a register.
- R7: Opcode 10 compares the registers in [11:8] and [7:4]. If they are equal, the PC becomes PC+2 plus twice the sign-extended immediate; otherwise it becomes PC+2.
- R8: Opcode 11 (jump) and opcode 12 (jump-and-link) load the PC with {(PC+2)[15:13], bits [11:0], 0}. Jump-and-link also writes PC+2 to register 15.
- R9: Opcode 13 loads the PC with the value of the register in [11:8].
- R10: Register 0 always reads zero. Any write to it is discarded.
- R11: A write on the load port stores a word into instruction memory at the given word index. The debug port returns the data memory word at the given word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_we | input | 1 | Instruction memory write strobe |
| load_idx | input | 7 | Instruction memory word index |
| load_word | input | 16 | Instruction word to store |
| dbg_idx | input | 7 | Data memory word index for debug read |
| dbg_word | output | 16 | Data memory word at `dbg_idx` |
| pc_o | output | 16 | Current program counter (byte address) |

## Verification
Two functions can land on the same edge in this block.

The first is a register-file read and a write to that same register within one instruction. The program doubles a register into itself (`add r1,r1,r1`), and the check is that the old value was used.

The second is jump-and-link, which writes register 15 on the same edge that it redirects the PC. The bench compares the PC against a behavioural model after every edge. It then stores every register, including r15 and r0, to data memory and reads those words back through the debug port, so the link value and the discarded r0 write are both judged.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
  localparam int XLEN  = 16;
  localparam int FLD_W = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_SUB = 4'h1, OP_AND = 4'h2, OP_OR  = 4'h3,
    OP_SLT  = 4'h4, OP_SLL = 4'h5, OP_SRL = 4'h6, OP_ADDI = 4'h7,
    OP_LW   = 4'h8, OP_SW  = 4'h9, OP_BEQ = 4'hA, OP_J   = 4'hB,
    OP_JAL  = 4'hC, OP_JR  = 4'hD, OP_NOR = 4'hE, OP_XOR = 4'hF
  } opcode_e;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT,
    ALU_SLL, ALU_SRL, ALU_NOR, ALU_XOR
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_RT   = 2'd0,
    DST_RD   = 2'd1,
    DST_LINK = 2'd2
  } dst_sel_e;

  typedef struct packed {
    logic     reg_write;
    dst_sel_e dst_sel;
    logic     alu_src;
    logic     branch;
    logic     mem_write;
    logic     mem_to_reg;
    logic     jump;
    logic     jump_reg;
  } ctrl_t;

  // widen a 4-bit signed field
  function automatic logic [XLEN-1:0] sext_imm(input logic [FLD_W-1:0] f);
    return {{(XLEN-FLD_W){f[FLD_W-1]}}, f};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] y;
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLL: y = a << b[FLD_W-1:0];
      ALU_SRL: y = a >> b[FLD_W-1:0];
      ALU_NOR: y = ~(a | b);
      ALU_XOR: y = a ^ b;
      default: y = a + b;
    endcase
    return y;
  endfunction

  // word offset doubled, added to the sequential PC
  function automatic logic [XLEN-1:0] branch_target(input logic [XLEN-1:0] pcp2,
                                                    input logic [FLD_W-1:0] imm);
    return pcp2 + (sext_imm(imm) << 1);
  endfunction

  function automatic logic [XLEN-1:0] jump_target(input logic [2:0] pc_hi,
                                                  input logic [3*FLD_W-1:0] addr);
    return {pc_hi, addr, 1'b0};
  endfunction
endpackage

// File: rtl/cpu16_decode.sv
module cpu16_decode
  import cpu16_pkg::*;
(
  input  logic [3:0] opcode,
  output ctrl_t      ctrl,
  output alu_op_e    alu_op
);
  // main decoder
  always_comb begin
    ctrl.reg_write  = 1'b0;
    ctrl.dst_sel    = DST_RT;
    ctrl.alu_src    = 1'b0;
    ctrl.branch     = 1'b0;
    ctrl.mem_write  = 1'b0;
    ctrl.mem_to_reg = 1'b0;
    ctrl.jump       = 1'b0;
    ctrl.jump_reg   = 1'b0;
    case (opcode)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SLT, OP_NOR, OP_XOR: begin
        ctrl.reg_write = 1'b1;
        ctrl.dst_sel   = DST_RD;
      end
      OP_SLL, OP_SRL, OP_ADDI: begin
        ctrl.reg_write = 1'b1;
        ctrl.alu_src   = 1'b1;
      end
      OP_LW: begin
        ctrl.reg_write  = 1'b1;
        ctrl.alu_src    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OP_SW: begin
        ctrl.alu_src   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ: ctrl.branch = 1'b1;
      OP_J:   ctrl.jump   = 1'b1;
      OP_JAL: begin
        ctrl.jump      = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.dst_sel   = DST_LINK;
      end
      OP_JR:  ctrl.jump_reg = 1'b1;
      default: ctrl.reg_write = 1'b0;
    endcase
  end

  // ALU decoder
  always_comb begin
    case (opcode)
      OP_SUB, OP_BEQ: alu_op = ALU_SUB;
      OP_AND:         alu_op = ALU_AND;
      OP_OR:          alu_op = ALU_OR;
      OP_SLT:         alu_op = ALU_SLT;
      OP_SLL:         alu_op = ALU_SLL;
      OP_SRL:         alu_op = ALU_SRL;
      OP_NOR:         alu_op = ALU_NOR;
      OP_XOR:         alu_op = ALU_XOR;
      default:        alu_op = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter  int NREG = 16,
  parameter  int W    = 16,
  parameter  int NRD  = 2,
  localparam int AW   = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [W-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][W-1:0]  rdata
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
  end

  // R3
  rf_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/cpu16_dmem.sv
module cpu16_dmem #(
  parameter  int BYTES = 256,
  parameter  int W     = 16,
  localparam int WORDS = BYTES / (W / 8),
  localparam int IW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [IW-1:0] dbg_idx,
  output logic [W-1:0]  dbg_rdata
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata     = mem[idx];
  assign dbg_rdata = mem[dbg_idx];
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter  int IM_WORDS = 128,
  parameter  int DM_BYTES = 256,
  parameter  int NREG     = 16,
  localparam int IM_AW    = $clog2(IM_WORDS),
  localparam int DM_IW    = $clog2(DM_BYTES / 2),
  localparam int RAW      = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_we,
  input  logic [IM_AW-1:0] load_idx,
  input  logic [XLEN-1:0]  load_word,
  input  logic [DM_IW-1:0] dbg_idx,
  output logic [XLEN-1:0]  dbg_word,
  output logic [XLEN-1:0]  pc_o
);
  localparam logic [RAW-1:0] LINK_REG = RAW'(NREG - 1);

  // fetch
  logic [XLEN-1:0] pc, pc_next, pc_plus2;
  logic [XLEN-1:0] imem [IM_WORDS];
  logic [XLEN-1:0] instr;

  always_ff @(posedge clk) begin
    if (load_we) imem[load_idx] <= load_word;
  end

  assign instr    = imem[pc[IM_AW:1]];
  assign pc_plus2 = pc + 16'd2;

  // fields
  logic [3:0] f_op, f_rs, f_rt, f_lo;
  assign {f_op, f_rs, f_rt, f_lo} = instr;

  ctrl_t   ctrl;
  alu_op_e alu_op;

  cpu16_decode u_dec (
    .opcode (f_op),
    .ctrl   (ctrl),
    .alu_op (alu_op)
  );

  // register file
  logic [1:0][RAW-1:0]  rf_raddr;
  logic [1:0][XLEN-1:0] rf_rdata;
  logic [XLEN-1:0]      rs_val, rt_val, wb_data;
  logic [RAW-1:0]       wb_idx;
  logic [XLEN-1:0]      dm_rdata;

  assign rf_raddr[0] = f_rs;
  assign rf_raddr[1] = f_rt;
  assign rs_val      = rf_rdata[0];
  assign rt_val      = rf_rdata[1];

  cpu16_regfile #(.NREG(NREG), .W(XLEN), .NRD(2)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (ctrl.reg_write),
    .waddr (wb_idx),
    .wdata (wb_data),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  // execute
  logic [XLEN-1:0] alu_b, alu_y;
  logic            alu_zero;

  assign alu_b    = ctrl.alu_src ? sext_imm(f_lo) : rt_val;
  assign alu_y    = alu_eval(alu_op, rs_val, alu_b);
  assign alu_zero = (alu_y == '0);

  // memory
  cpu16_dmem #(.BYTES(DM_BYTES), .W(XLEN)) u_dm (
    .clk       (clk),
    .we        (ctrl.mem_write),
    .idx       (alu_y[DM_IW:1]),
    .wdata     (rt_val),
    .rdata     (dm_rdata),
    .dbg_idx   (dbg_idx),
    .dbg_rdata (dbg_word)
  );

  // write back
  always_comb begin
    case (ctrl.dst_sel)
      DST_RD:   wb_idx = f_lo;
      DST_LINK: wb_idx = LINK_REG;
      default:  wb_idx = f_rt;
    endcase
  end

  always_comb begin
    if (ctrl.dst_sel == DST_LINK) wb_data = pc_plus2;
    else if (ctrl.mem_to_reg)     wb_data = dm_rdata;
    else                          wb_data = alu_y;
  end

  // next PC, events named for the checks below
  logic            take_branch, take_jump, take_jr;
  logic [XLEN-1:0] branch_tgt, jump_tgt;

  assign take_branch = ctrl.branch & alu_zero;
  assign take_jump   = ctrl.jump;
  assign take_jr     = ctrl.jump_reg;
  assign branch_tgt  = branch_target(pc_plus2, f_lo);
  assign jump_tgt    = jump_target(pc_plus2[XLEN-1:XLEN-3], instr[11:0]);

  always_comb begin
    if (take_jr)          pc_next = rs_val;
    else if (take_jump)   pc_next = jump_tgt;
    else if (take_branch) pc_next = branch_tgt;
    else                  pc_next = pc_plus2;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign pc_o = pc;

  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> pc == '0);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!take_branch && !take_jump && !take_jr) |=> pc == $past(pc) + 16'd2);

  // R2
  pc_even_chk: assert property (@(posedge clk) disable iff (rst) pc[0] == 1'b0);

  // R7
  branch_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    take_branch |=> pc == $past(branch_tgt));

  // R7
  ctl_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.branch, ctrl.jump, ctrl.jump_reg}));

  // R8
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    take_jump |=> pc == $past(jump_tgt));

  // R9
  jr_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    take_jr |=> pc == $past(rs_val));

  // R6
  store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.mem_write |-> !ctrl.reg_write);
endmodule

// File: tb/tb_cpu16_core.sv
`timescale 1ns/1ps
module tb_cpu16_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_we = 1'b0;
  logic [6:0]  load_idx = '0;
  logic [15:0] load_word = '0;
  logic [6:0]  dbg_idx = '0;
  logic [15:0] dbg_word;
  logic [15:0] pc_o;

  always #10 clk = ~clk;

  cpu16_core dut (
    .clk(clk), .rst(rst), .load_we(load_we), .load_idx(load_idx),
    .load_word(load_word), .dbg_idx(dbg_idx), .dbg_word(dbg_word), .pc_o(pc_o)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;

  // reference state
  logic [15:0] prog [128];
  logic [15:0] mreg [16];
  string       mreg_tag [16];
  logic [15:0] mmem [128];
  bit          mwr [128];
  string       mmem_tag [128];
  logic [15:0] mpc;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input int op, input int a, input int b, input int c);
    return {op[3:0], a[3:0], b[3:0], c[3:0]};
  endfunction

  function automatic logic [15:0] jins(input int op, input int addr);
    return {op[3:0], addr[11:0]};
  endfunction

  task automatic mreset();
    mpc = '0;
    for (int i = 0; i < 16; i++) begin
      mreg[i] = '0;
      mreg_tag[i] = "R1";
    end
  endtask

  task automatic mwrite(input int k, input logic [15:0] v, input string tag);
    if (k != 0) begin
      mreg[k] = v;
      mreg_tag[k] = tag;
    end
  endtask

  // one instruction of the behavioural model; returns the requirement it exercises
  task automatic model_step(output string tag);
    logic [15:0] w, a, b, sx, nxt, ea;
    int op, s, t, d;
    w  = prog[mpc[7:1]];
    op = int'(w[15:12]); s = int'(w[11:8]); t = int'(w[7:4]); d = int'(w[3:0]);
    a  = (s == 0) ? 16'h0 : mreg[s];
    b  = (t == 0) ? 16'h0 : mreg[t];
    sx = (d >= 8) ? 16'(d - 16) : 16'(d);
    nxt = mpc + 16'd2;
    ea = (a + sx) & 16'h00FF;
    case (op)
      0:  begin tag = "R3 add"; mwrite(d, a + b, tag); end
      1:  begin tag = "R3 sub"; mwrite(d, a - b, tag); end
      2:  begin tag = "R3 and"; mwrite(d, a & b, tag); end
      3:  begin tag = "R3 or";  mwrite(d, a | b, tag); end
      4:  begin tag = "R3 slt"; mwrite(d, ($signed(a) < $signed(b)) ? 16'd1 : 16'd0, tag); end
      5:  begin tag = "R4 sll"; mwrite(t, a << d, tag); end
      6:  begin tag = "R4 srl"; mwrite(t, a >> d, tag); end
      7:  begin tag = "R5 addi"; mwrite(t, a + sx, tag); end
      8:  begin tag = "R6 load"; mwrite(t, mmem[ea[7:1]], tag); end
      9:  begin
            tag = "R6 store";
            mmem[ea[7:1]] = b;
            mwr[ea[7:1]] = 1'b1;
            mmem_tag[ea[7:1]] = (t == 0) ? "R10" : mreg_tag[t];
          end
      10: begin tag = "R7 beq"; if (a == b) nxt = nxt + 16'(int'(sx) * 2); end
      11: begin tag = "R8 j"; nxt = {nxt[15:13], w[11:0], 1'b0}; end
      12: begin tag = "R8 jal"; mwrite(15, mpc + 16'd2, tag); nxt = {nxt[15:13], w[11:0], 1'b0}; end
      13: begin tag = "R9 jr"; nxt = a; end
      14: begin tag = "R3 nor"; mwrite(d, ~(a | b), tag); end
      default: begin tag = "R3 xor"; mwrite(d, a ^ b, tag); end
    endcase
    if (nxt != mpc + 16'd2 && op < 10) tag = {tag, " R2"};
    mpc = nxt;
  endtask

  task automatic load_word_at(input int idx, input logic [15:0] v);
    load_we = 1'b1; load_idx = 7'(idx); load_word = v;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic run_steps(input int n);
    string tag;
    for (int i = 0; i < n; i++) begin
      model_step(tag);
      @(negedge clk);
      chk({tag, " pc"}, pc_o, mpc);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    int ip;
    for (int i = 0; i < 128; i++) begin
      prog[i] = 16'h0000;
      mwr[i]  = 1'b0;
    end
    ip = 0;
    prog[ip++] = ins(7, 0, 1, 7);     // r1 = 7
    prog[ip++] = ins(7, 0, 2, 8);     // r2 = -8
    prog[ip++] = ins(0, 1, 2, 3);     // add
    prog[ip++] = ins(1, 1, 2, 4);     // sub -> 15
    prog[ip++] = ins(2, 1, 2, 5);
    prog[ip++] = ins(3, 1, 2, 6);
    prog[ip++] = ins(4, 2, 1, 7);     // slt signed -> 1
    prog[ip++] = ins(5, 1, 8, 4);     // sll 4
    prog[ip++] = ins(6, 2, 9, 3);     // srl 3
    prog[ip++] = ins(14, 1, 2, 10);
    prog[ip++] = ins(15, 1, 2, 11);
    prog[ip++] = ins(9, 1, 4, 2);     // store at byte 9 (bit 0 dropped)
    prog[ip++] = ins(8, 1, 12, 1);    // load from byte 8
    prog[ip++] = ins(7, 1, 0, 1);     // write to r0, discarded
    prog[ip++] = ins(9, 1, 0, 6);     // store r0
    prog[ip++] = ins(0, 1, 1, 1);     // r1 = r1 + r1, same-cycle read/write
    prog[ip++] = ins(10, 1, 4, 2);    // not taken
    prog[ip++] = ins(10, 4, 12, 1);   // taken, skips one
    prog[ip++] = ins(7, 0, 1, 1);     // skipped
    prog[ip++] = jins(12, 100);       // call
    prog[ip++] = ins(0, 8, 0, 13);    // base = r8
    for (int k = 1; k < 16; k++) begin
      if (k != 13) begin
        prog[ip++] = ins(9, 13, k, 0);
        prog[ip++] = ins(7, 13, 13, 2);
      end
    end
    prog[ip] = jins(11, ip);          // halt loop
    prog[100] = ins(7, 0, 13, 5);
    prog[101] = ins(7, 13, 13, 15);   // decrement
    prog[102] = ins(4, 0, 13, 14);
    prog[103] = ins(10, 14, 7, 13);   // backward branch -3
    prog[104] = ins(13, 15, 0, 0);    // return

    repeat (2) @(negedge clk);
    for (int i = 0; i < 128; i++) load_word_at(i, prog[i]);   // R11 load port
    @(negedge clk);
    chk("R1 pc held in reset", pc_o, 16'h0000);
    rst = 1'b0;
    mreset();
    chk("R1 pc after reset", pc_o, 16'h0000);
    run_steps(130);

    // second program after a mid-run reset: registers must be cleared
    rst = 1'b1;
    prog[0] = ins(9, 0, 4, 6);        // store r4 to byte 6
    prog[1] = jins(11, 1);
    load_word_at(0, prog[0]);
    load_word_at(1, prog[1]);
    chk("R1 pc in second reset", pc_o, 16'h0000);
    rst = 1'b0;
    mreset();
    run_steps(8);

    for (int w = 0; w < 128; w++) begin
      if (mwr[w]) begin
        dbg_idx = 7'(w);
        #1;
        chk($sformatf("%s word %0d via debug port R11", mmem_tag[w], w), dbg_word, mmem[w]);
      end
    end
    finish_run();
  end
endmodule